// File: doc/BRIEF.md
# Integer Compare and Byte-Match Unit

This datapath block serves the integer side of a 32-bit soft processor. It takes two operands, a carry input and a 2-bit operation code. It can produce four results:

- a signed compare result;
- an unsigned compare result;
- the carry out of a three-input addition;
- the index of the first byte lane in which the two operands hold the same byte.

The arithmetic is purely combinational. A single output register stage captures each issued operation and raises a valid strobe one clock later. The surrounding pipeline can therefore take the result at a fixed point.

The compare results are not a plain flag. Each is the 32-bit difference `b - a`. When the operand signs differ, its top bit is replaced by the sign of one operand, so the top bit alone orders the operands correctly. Signed compare takes the sign of `b`; unsigned compare takes the sign of `a`. Byte matching scans from the most significant byte towards the least significant one and stops at the first equal lane.

Top module: `cmu_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `result`, `carry_out` and `out_valid` are all cleared to zero.
- R2: `out_valid` equals the value `in_valid` had at the previous rising edge; each issued operation yields exactly one valid result.
- R3: When `in_valid` is low at a rising edge, `result` and `carry_out` keep their previous values.
- R4: With `op` = 2'b00 (signed compare), `result` is `b - a` modulo 2^32. If bit 31 of `a` differs from bit 31 of `b`, bit 31 of `result` is bit 31 of `b` instead.
- R5: With `op` = 2'b01 (unsigned compare), `result` is `b - a` modulo 2^32. If bit 31 of `a` differs from bit 31 of `b`, bit 31 of `result` is bit 31 of `a` instead.
- R6: With `op` = 2'b10 (carry), `carry_out` is the carry out of the 32-bit sum `a + b + carry_in`. `result` is that bit in position 0 with all other bits zero.
- R7: For every `op` other than 2'b10, the registered `carry_out` is zero.
- R8: With `op` = 2'b11 (byte match), lanes are examined in the order bits 31:24, 23:16, 15:8, 7:0. `result` is 1, 2, 3 or 4 for the first lane in that order whose bytes in `a` and `b` are equal.
- R9: With `op` = 2'b11, `result` is 0 when no lane holds equal bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Issue strobe: capture this cycle's operation |
| op | input | 2 | Operation code: 00 signed compare, 01 unsigned compare, 10 carry, 11 byte match |
| opnd_a | input | 32 | Operand a |
| opnd_b | input | 32 | Operand b |
| carry_in | input | 1 | Carry input for the carry operation |
| out_valid | output | 1 | Result strobe, one cycle after issue |
| result | output | 32 | Registered result |
| carry_out | output | 1 | Registered carry output |

## Verification
Several properties are checked by assertions on every cycle after reset:

- the one-cycle valid delay;
- that the outputs hold while nothing is issued;
- that `carry_out` stays clear outside the carry operation;
- that a carry result has only bit 0 set, mirroring `carry_out`;
- that a byte-match index never exceeds four;
- that equal operands give a zero compare difference.

Other behaviours can only be shown by the bench's scenarios, which are compared against an independent model:

- the exact compare values and which operand's sign replaces the top bit;
- the carry at the all-ones boundaries;
- lane priority when several lanes match;
- the zero result when no lane matches.

// File: rtl/cmu_pkg.sv
// Package: shared operation codes and widths for the compare/byte-match unit.
// Assumes: operand width is a whole number of byte lanes.
package cmu_pkg;

    typedef enum logic [1:0] {
        OP_SCMP   = 2'b00,
        OP_UCMP   = 2'b01,
        OP_CARRY  = 2'b10,
        OP_BMATCH = 2'b11
    } cmu_op_e;

    localparam int unsigned CMU_DATA_W = 32;
    localparam int unsigned CMU_LANE_W = 8;

endpackage

// File: rtl/cmu_compare.sv
// Module: compare datapath. Forms b - a as b + ~a + 1. When the operand
// signs differ, the top bit is replaced by the sign of b (signed variant)
// or of a (unsigned variant), chosen by the UNSIGNED_MODE parameter.
// Assumes: purely combinational, operands stable for the cycle.
module cmu_compare #(
    parameter int unsigned DATA_W        = 32,
    parameter bit          UNSIGNED_MODE = 1'b0
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] cmp_o
);
    localparam int unsigned MSB = DATA_W - 1;

    logic [DATA_W-1:0] diff;
    logic              signs_differ;
    logic              sign_src;

    // Two's-complement subtraction b - a
    always_comb diff = opnd_b + ~opnd_a + {{(DATA_W-1){1'b0}}, 1'b1};

    always_comb signs_differ = opnd_a[MSB] ^ opnd_b[MSB];

    generate
        if (UNSIGNED_MODE) begin : g_uns
            // Unsigned order: sign taken from a
            always_comb sign_src = opnd_a[MSB];
        end else begin : g_sgn
            // Signed order: sign taken from b
            always_comb sign_src = opnd_b[MSB];
        end
    endgenerate

    // Patch the top bit only when the signs disagree
    always_comb cmp_o = signs_differ ? {sign_src, diff[MSB-1:0]} : diff;

    // R4 / R5: identical operands must leave a zero difference
    always_comb begin
        p_equal_zero_r4: assert (opnd_a != opnd_b || cmp_o == '0)
            else $error("equal operands gave non-zero compare");
    end
endmodule

// File: rtl/cmu_carry.sv
// Module: carry-out of a + b + cin. Carry is set when b is all ones and
// cin is set, or when the headroom ~a is smaller than b + cin.
// Assumes: purely combinational.
module cmu_carry #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              carry_in,
    output logic              carry_o
);
    logic [DATA_W-1:0] headroom;
    logic [DATA_W-1:0] b_plus_c;

    // Space left above a before wrap
    always_comb headroom = ~opnd_a;
    // b plus incoming carry (wraps only in the all-ones case handled below)
    always_comb b_plus_c = opnd_b + {{(DATA_W-1){1'b0}}, carry_in};
    // Combine the wrap case and the headroom test
    always_comb carry_o = ((&opnd_b) & carry_in) | (headroom < b_plus_c);
endmodule

// File: rtl/cmu_bytematch.sv
// Module: byte-lane matcher. Lane 0 is the most significant byte. Returns
// the 1-based index of the first equal lane, scanning from lane 0, or 0.
// Assumes: DATA_W is a multiple of LANE_W; purely combinational.
module cmu_bytematch #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned LANES = DATA_W / LANE_W,
    localparam int unsigned IDX_W = $clog2(LANES + 1)
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [IDX_W-1:0]  idx_o
);
    logic [LANES-1:0] lane_eq;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            localparam int unsigned HI = DATA_W - 1 - g * LANE_W;
            // Equality of one byte lane
            always_comb lane_eq[g] = (opnd_a[HI -: LANE_W] == opnd_b[HI -: LANE_W]);
        end
    endgenerate

    // Priority pick: the lowest lane number (most significant byte) wins
    always_comb begin
        idx_o = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (lane_eq[i]) idx_o = IDX_W'(i + 1);
        end
    end

    // R9: a zero index means no lane was equal
    always_comb begin
        p_zero_means_none_r9: assert (idx_o != '0 || lane_eq == '0)
            else $error("zero index while a lane matched");
    end
endmodule

// File: rtl/cmu_unit.sv
// Module: top of the compare/byte-match unit. Selects one of the four
// datapath results and registers it with a one-cycle valid strobe.
// Assumes: synchronous active-low reset; the result only loads on in_valid.
module cmu_unit
    import cmu_pkg::*;
#(
    parameter int unsigned DATA_W = CMU_DATA_W,
    parameter int unsigned LANE_W = CMU_LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              carry_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              carry_out
);
    localparam int unsigned LANES = DATA_W / LANE_W;
    localparam int unsigned IDX_W = $clog2(LANES + 1);

    logic [DATA_W-1:0] scmp_res;
    logic [DATA_W-1:0] ucmp_res;
    logic              cy_res;
    logic [IDX_W-1:0]  match_idx;
    logic [DATA_W-1:0] res_next;
    logic              cy_next;
    cmu_op_e           op_e;

    always_comb op_e = cmu_op_e'(op);

    cmu_compare #(.DATA_W(DATA_W), .UNSIGNED_MODE(1'b0)) u_scmp (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .cmp_o(scmp_res));

    cmu_compare #(.DATA_W(DATA_W), .UNSIGNED_MODE(1'b1)) u_ucmp (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .cmp_o(ucmp_res));

    cmu_carry #(.DATA_W(DATA_W)) u_carry (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in), .carry_o(cy_res));

    cmu_bytematch #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_match (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .idx_o(match_idx));

    // Select the result for the requested operation
    always_comb begin
        res_next = '0;
        cy_next  = 1'b0;
        unique case (op_e)
            OP_SCMP:   res_next = scmp_res;
            OP_UCMP:   res_next = ucmp_res;
            OP_CARRY: begin
                res_next = {{(DATA_W-1){1'b0}}, cy_res};
                cy_next  = cy_res;
            end
            OP_BMATCH: res_next = {{(DATA_W-IDX_W){1'b0}}, match_idx};
            default:   res_next = '0;
        endcase
    end

    // Output stage: valid follows issue, data loads only on issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            carry_out <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= res_next;
                carry_out <= cy_next;
            end
        end
    end

    // R2: valid output is the issue strobe delayed by one cycle
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R3: no issue, no change
    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> ($stable(result) && $stable(carry_out)));

    // R6: carry result has only bit 0, mirroring carry_out
    p_carry_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(op) == OP_CARRY) |->
            (result[DATA_W-1:1] == '0 && result[0] == carry_out));

    // R7: carry_out stays clear for the other operations
    p_carry_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(op) != OP_CARRY) |-> !carry_out);

    // R8: byte-match index never exceeds the lane count
    p_match_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(op) == OP_BMATCH) |->
            (result <= DATA_W'(LANES)));
endmodule

// File: tb/cmu_unit_bench.sv
`timescale 1ns/1ps
module cmu_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        carry_in = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        carry_out;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [31:0] res;
        logic        cy;
        string       req;
    } exp_t;
    exp_t sb[$];

    logic [31:0] last_res = '0;
    logic        last_cy  = 1'b0;

    always #2.5 clk = ~clk;

    cmu_unit u_cmu_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
        .out_valid(out_valid), .result(result), .carry_out(carry_out));

    task automatic check(input bit ok, input string req, input logic [32:0] act, input logic [32:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_cmp(input logic [31:0] a, input logic [31:0] b, input bit uns);
        logic [31:0] d;
        d = b - a;
        if (a[31] != b[31]) d[31] = uns ? a[31] : b[31];
        return d;
    endfunction

    function automatic logic model_carry(input logic [31:0] a, input logic [31:0] b, input logic c);
        logic [32:0] s;
        s = {1'b0, a} + {1'b0, b} + {32'b0, c};
        return s[32];
    endfunction

    function automatic logic [31:0] model_match(input logic [31:0] a, input logic [31:0] b);
        for (int k = 0; k < 4; k++) begin
            if (a[31-8*k -: 8] == b[31-8*k -: 8]) return 32'(k + 1);
        end
        return 32'd0;
    endfunction

    // Driver: issue one operation and push its expected outcome
    task automatic issue(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic c, input string req);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; op = o; opnd_a = a; opnd_b = b; carry_in = c;
        e.req = req;
        e.cy  = 1'b0;
        case (o)
            2'b00: e.res = model_cmp(a, b, 1'b0);
            2'b01: e.res = model_cmp(a, b, 1'b1);
            2'b10: begin e.cy = model_carry(a, b, c); e.res = {31'b0, e.cy}; end
            default: e.res = model_match(a, b);
        endcase
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            opnd_a = $urandom; opnd_b = $urandom; op = 2'(k);
        end
    endtask

    // Monitor: pop and compare, and check holding while idle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst_n) begin
                last_res = '0; last_cy = 1'b0;
            end else if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2 unexpected valid", 33'(out_valid), 33'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(result == e.res && carry_out == e.cy, e.req,
                          {carry_out, result}, {e.cy, e.res});
                    last_res = result; last_cy = carry_out;
                end
            end else begin
                check(result == last_res && carry_out == last_cy, "R3 hold while idle",
                      {carry_out, result}, {last_cy, last_res});
            end
        end
    end

    initial begin
        #200000;
        check(1'b0, "watchdog", 33'd0, 33'd1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(result == 0 && carry_out == 0 && out_valid == 0, "R1 reset",
              {carry_out, result}, 33'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4 signed compare
        issue(2'b00, 32'd5, 32'd3, 1'b0, "R4 same sign");
        issue(2'b00, 32'h8000_0000, 32'd1, 1'b0, "R4 sign differ");
        issue(2'b00, 32'd7, 32'hFFFF_FFF0, 1'b0, "R4 b negative");
        issue(2'b00, 32'h1234_5678, 32'h1234_5678, 1'b0, "R4 equal");
        // R5 unsigned compare
        issue(2'b01, 32'h8000_0000, 32'd1, 1'b0, "R5 sign differ");
        issue(2'b01, 32'd3, 32'd5, 1'b0, "R5 same sign");
        issue(2'b01, 32'hFFFF_FFFF, 32'd0, 1'b0, "R5 max vs zero");
        idle(2);
        // R6 carry boundaries
        issue(2'b10, 32'hFFFF_FFFF, 32'd0, 1'b1, "R6 a ones cin");
        issue(2'b10, 32'd0, 32'hFFFF_FFFF, 1'b1, "R6 b ones cin");
        issue(2'b10, 32'd0, 32'hFFFF_FFFF, 1'b0, "R6 b ones no cin");
        issue(2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R6 both ones");
        issue(2'b10, 32'd1, 32'd2, 1'b1, "R6 small");
        // R7 carry_out cleared by following non-carry op
        issue(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R7 clear after carry");
        // R8 / R9 byte match
        issue(2'b11, 32'hAA11_2233, 32'hAA99_2233, 1'b0, "R8 top lane wins");
        issue(2'b11, 32'h0011_2233, 32'hFF11_2299, 1'b0, "R8 lane 2");
        issue(2'b11, 32'h0102_0304, 32'h1112_0314, 1'b0, "R8 lane 3");
        issue(2'b11, 32'h0102_0304, 32'h1112_1304, 1'b0, "R8 lane 4");
        issue(2'b11, 32'h0102_0304, 32'h1112_1314, 1'b0, "R9 none");
        idle(3);
        for (int k = 0; k < 200; k++) begin
            logic [31:0] ra, rb;
            ra = $urandom; rb = $urandom;
            if (k % 3 == 0) rb[15:8] = ra[15:8];
            issue(2'(k % 4), ra, rb, 1'(k[2]), "R4 R5 R6 R8 mixed");
            if (k % 7 == 0) idle(1);
        end
        idle(3);
        check(sb.size() == 0, "R2 all results delivered", 33'(sb.size()), 33'd0);

        // R1 reset in mid-run
        issue(2'b10, 32'hFFFF_FFFF, 32'd1, 1'b0, "R6 before reset");
        idle(2);
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        #1;
        check(result == 0 && carry_out == 0 && out_valid == 0, "R1 mid-run reset",
              {carry_out, result}, 33'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule